// File: doc/BRIEF.md
# Compare-and-Swap Memory Handler

This block is the memory-cache side of a conditional store implemented as a compare-and-swap. A requester presents a command tagged with its requester ID. A conditional store carries the value the requester read earlier and the value it now wants stored. The handler reads the stored word or word pair and compares it with the carried value. When the two match, it writes the new value and pushes the new data to every requester that holds a copy of the line. It answers only after every one of those copies has acknowledged.

Plain writes and reads use the same storage. A write pushes its data to every copy holder except the writer. A cacheable read enrols the reader as a copy holder. A small internal word array stands in for the cache data, and a bit-vector per line records the copy holders. Update requests leave on a valid/ready handshake, one per cycle, and acknowledgements return as single-cycle pulses. No new command is taken while any update is unsent or unacknowledged, so each compare-and-swap is atomic against every other command.

Top module: `cas_handler`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` and `upd_valid` are 0, every stored word is zero, and no line has any copy holder.
- R2: Command opcodes are read=0, write=1, compare-and-swap=2. An accepted read answers in the next cycle with the addressed data and the requester ID. A 32-bit access returns the word in bits 31:0 with the upper bits zero. A 64-bit access (`cmd_wide`=1) returns the pair at the even address, with the even word in bits 31:0 and the odd word in bits 63:32.
- R3: A read with `cmd_cached`=1 sets the requester's bit in the sharer set of its line. A line is 4 consecutive words, so the line index is address/4. A read with `cmd_cached`=0 leaves the sharer set unchanged.
- R4: A compare-and-swap whose expected value equals the stored value writes the new value and answers with data 0 (success).
- R5: A compare-and-swap whose expected value differs writes nothing, sends no update, and answers with data 1 (failure) in the next cycle.
- R6: A successful compare-and-swap sends one update carrying the new value to every copy holder of the line, including the requester.
- R7: A write stores its data, sends one update to every copy holder of the line except the writer, and answers with data 0.
- R8: Updates go out in ascending requester-ID order, at most one per cycle. While `upd_ready` is 0, a pending update holds its destination and data.
- R9: A write or a successful compare-and-swap answers only after one `ack_valid` pulse has been received for each update sent.
- R10: `cmd_ready` stays 0 from acceptance of a write or a successful compare-and-swap until its answer.
- R11: A 64-bit compare-and-swap compares both words and fails if either word differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Handler can accept a command |
| cmd_op | input | 2 | 0 read, 1 write, 2 compare-and-swap |
| cmd_cached | input | 1 | Read enrols the requester as a copy holder |
| cmd_wide | input | 1 | 64-bit access on an even/odd word pair |
| cmd_src | input | 2 | Requester ID |
| cmd_addr | input | 4 | Word address |
| cmd_expect | input | 64 | Value the requester expects to be stored |
| cmd_wdata | input | 64 | Value to store |
| rsp_valid | output | 1 | Single-cycle answer pulse |
| rsp_src | output | 2 | Requester the answer is for |
| rsp_data | output | 64 | Read data, or 0 for success and 1 for failure |
| upd_valid | output | 1 | Update request pending |
| upd_ready | input | 1 | Update request taken |
| upd_dst | output | 2 | Copy holder the update is for |
| upd_addr | output | 4 | Address of the updated data |
| upd_data | output | 64 | New data |
| ack_valid | input | 1 | One acknowledgement of an update |

## Verification
The hardest situation to reach from the ports is a busy window in which updates are still stalled and acknowledgements are still held back, while a competing command waits. In that window the handler must keep `cmd_ready` low, keep its pending update steady, and withhold the answer. The bench reaches it with cacheable reads that make every other requester a copy holder of one line. It then issues a write with `upd_ready` forced low and the acknowledgement responder paused, checks the ports over several cycles, and releases first the handshake and then the acknowledgements.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CAS   = 2'd2
    } op_e;

    localparam logic [63:0] RSP_OK   = 64'd0;
    localparam logic [63:0] RSP_FAIL = 64'd1;
endpackage

// File: rtl/cas_pick.sv
module cas_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/cas_store.sv
module cas_store #(
    parameter int WORDS      = 16,
    parameter int LINE_WORDS = 4,
    parameter int NSRC       = 4,
    localparam int AW    = $clog2(WORDS),
    localparam int LWW   = $clog2(LINE_WORDS),
    localparam int LINES = WORDS / LINE_WORDS,
    localparam int SW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    output logic [31:0]     rd_word,
    output logic [63:0]     rd_pair,
    output logic [NSRC-1:0] sharers,
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [63:0]     wr_data,
    input  logic            sh_set,
    input  logic [SW-1:0]   sh_src
);
    logic [WORDS-1:0][31:0]     mem_d, mem_q;
    logic [LINES-1:0][NSRC-1:0] sh_d, sh_q;
    logic [AW-1:0]              even_a, odd_a;
    logic [AW-LWW-1:0]          line_a;

    always_comb begin
        even_a  = {addr[AW-1:1], 1'b0};
        odd_a   = {addr[AW-1:1], 1'b1};
        line_a  = addr[AW-1:LWW];
        rd_word = mem_q[addr];
        rd_pair = {mem_q[odd_a], mem_q[even_a]};
        sharers = sh_q[line_a];
        mem_d   = mem_q;
        sh_d    = sh_q;
        if (wr_en) begin
            if (wr_wide) begin
                mem_d[even_a] = wr_data[31:0];
                mem_d[odd_a]  = wr_data[63:32];
            end else begin
                mem_d[addr] = wr_data[31:0];
            end
        end
        if (sh_set) sh_d[line_a][sh_src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            sh_q  <= '0;
        end else begin
            mem_q <= mem_d;
            sh_q  <= sh_d;
        end
    end
endmodule

// File: rtl/cas_handler.sv
module cas_handler #(
    parameter int WORDS      = 16,
    parameter int LINE_WORDS = 4,
    parameter int NSRC       = 4,
    localparam int AW = $clog2(WORDS),
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CW = $clog2(NSRC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_cached,
    input  logic          cmd_wide,
    input  logic [SW-1:0] cmd_src,
    input  logic [AW-1:0] cmd_addr,
    input  logic [63:0]   cmd_expect,
    input  logic [63:0]   cmd_wdata,
    output logic          rsp_valid,
    output logic [SW-1:0] rsp_src,
    output logic [63:0]   rsp_data,
    output logic          upd_valid,
    input  logic          upd_ready,
    output logic [SW-1:0] upd_dst,
    output logic [AW-1:0] upd_addr,
    output logic [63:0]   upd_data,
    input  logic          ack_valid
);
    import cas_pkg::*;

    typedef struct packed {
        logic            busy;
        logic [NSRC-1:0] pend;
        logic [CW-1:0]   cnt;
        logic [AW-1:0]   addr;
        logic [63:0]     data;
        logic [SW-1:0]   src;
        logic            rsp_v;
        logic [SW-1:0]   rsp_src;
        logic [63:0]     rsp_data;
    } state_t;

    state_t s_d, s_q;

    logic [31:0]     rd_word;
    logic [63:0]     rd_pair;
    logic [NSRC-1:0] sharers;
    logic            wr_en, sh_set;
    logic [63:0]     cur_val, exp_val, new_val;
    logic            match, accept;
    logic [NSRC-1:0] start_mask;
    logic            start;
    logic [SW-1:0]   pick_idx;
    logic            pick_any;

    cas_store #(.WORDS(WORDS), .LINE_WORDS(LINE_WORDS), .NSRC(NSRC)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(cmd_addr),
        .rd_word(rd_word), .rd_pair(rd_pair), .sharers(sharers),
        .wr_en(wr_en), .wr_wide(cmd_wide), .wr_data(new_val),
        .sh_set(sh_set), .sh_src(cmd_src)
    );

    cas_pick #(.N(NSRC)) u_pick (
        .mask(s_q.pend), .idx(pick_idx), .any(pick_any)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rsp_v  = 1'b0;
        wr_en      = 1'b0;
        sh_set     = 1'b0;
        start      = 1'b0;
        start_mask = '0;
        cmd_ready  = !s_q.busy;
        accept     = cmd_valid && cmd_ready;
        cur_val    = cmd_wide ? rd_pair : {32'd0, rd_word};
        exp_val    = cmd_wide ? cmd_expect : {32'd0, cmd_expect[31:0]};
        new_val    = cmd_wide ? cmd_wdata : {32'd0, cmd_wdata[31:0]};
        match      = (cur_val == exp_val);
        upd_valid  = s_q.busy && pick_any;
        upd_dst    = pick_idx;
        upd_addr   = s_q.addr;
        upd_data   = s_q.data;

        if (accept) begin
            case (op_e'(cmd_op))
                OP_READ: begin
                    s_d.rsp_v    = 1'b1;
                    s_d.rsp_src  = cmd_src;
                    s_d.rsp_data = cur_val;
                    sh_set       = cmd_cached;
                end
                OP_WRITE: begin
                    wr_en      = 1'b1;
                    start      = 1'b1;
                    start_mask = sharers & ~(NSRC'(1) << cmd_src);
                end
                OP_CAS: begin
                    if (match) begin
                        wr_en      = 1'b1;
                        start      = 1'b1;
                        start_mask = sharers;
                    end else begin
                        s_d.rsp_v    = 1'b1;
                        s_d.rsp_src  = cmd_src;
                        s_d.rsp_data = RSP_FAIL;
                    end
                end
                default: ;
            endcase
        end

        if (start) begin
            s_d.busy = 1'b1;
            s_d.pend = start_mask;
            s_d.cnt  = CW'($countones(start_mask));
            s_d.addr = cmd_addr;
            s_d.data = new_val;
            s_d.src  = cmd_src;
        end

        if (s_q.busy) begin
            if (upd_valid && upd_ready) s_d.pend[pick_idx] = 1'b0;
            if (ack_valid && s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.pend == '0 && s_q.cnt == '0) begin
                s_d.busy     = 1'b0;
                s_d.rsp_v    = 1'b1;
                s_d.rsp_src  = s_q.src;
                s_d.rsp_data = RSP_OK;
            end
        end

        rsp_valid = s_q.rsp_v;
        rsp_src   = s_q.rsp_src;
        rsp_data  = s_q.rsp_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0 || upd_valid) |-> !cmd_ready);

    // R9
    no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> !rsp_valid);

    // R8
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ready) |=> (upd_valid && $stable(upd_dst) && $stable(upd_data)));

    // R8
    upd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ready) |=> (!upd_valid || upd_dst > $past(upd_dst)));

    // R5
    cas_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd2 && !match) |=> (rsp_valid && rsp_data == RSP_FAIL && !upd_valid));

    // R2
    read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd0) |=> (rsp_valid && rsp_src == $past(cmd_src)));
endmodule

// File: tb/test_cas_handler.sv
module test_cas_handler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic        cmd_cached = 1'b0;
    logic        cmd_wide = 1'b0;
    logic [1:0]  cmd_src = '0;
    logic [3:0]  cmd_addr = '0;
    logic [63:0] cmd_expect = '0;
    logic [63:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_src;
    logic [63:0] rsp_data;
    logic        upd_valid;
    logic        upd_ready = 1'b1;
    logic [1:0]  upd_dst;
    logic [3:0]  upd_addr;
    logic [63:0] upd_data;
    logic        ack_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    int owed = 0;
    bit ack_hold = 1'b0;
    bit done = 1'b0;

    logic [31:0] mem [16];
    logic [3:0]  shr [4];
    logic [65:0] rsp_q [$];
    string       rsp_tag [$];
    logic [65:0] upd_q [$];
    string       upd_tag [$];

    always #5 clk = ~clk;

    cas_handler i_cas_handler (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_cached(cmd_cached), .cmd_wide(cmd_wide),
        .cmd_src(cmd_src), .cmd_addr(cmd_addr), .cmd_expect(cmd_expect),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_src(rsp_src),
        .rsp_data(rsp_data), .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_dst(upd_dst), .upd_addr(upd_addr), .upd_data(upd_data),
        .ack_valid(ack_valid)
    );

    task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mwrite(input int a, input logic wide, input logic [63:0] v);
        if (wide) begin
            mem[a & ~1] = v[31:0];
            mem[a | 1]  = v[63:32];
        end else begin
            mem[a] = v[31:0];
        end
    endtask

    task automatic push_upd(input int line, input int skip, input logic [63:0] v, input string tag);
        for (int d = 0; d < 4; d++) begin
            if (shr[line][d] && d != skip) begin
                upd_q.push_back({2'(d), v});
                upd_tag.push_back(tag);
            end
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic cached, input int src, input int a,
                          input logic wide, input logic [63:0] ex, input logic [63:0] wd,
                          input string tag);
        logic [63:0] cur, expv, nv;
        int line;
        line = a / 4;
        cur  = wide ? {mem[a | 1], mem[a & ~1]} : {32'd0, mem[a]};
        expv = wide ? ex : {32'd0, ex[31:0]};
        nv   = wide ? wd : {32'd0, wd[31:0]};
        case (op)
            2'd0: begin
                rsp_q.push_back({2'(src), cur}); rsp_tag.push_back(tag);
                if (cached) shr[line][src] = 1'b1;
            end
            2'd1: begin
                mwrite(a, wide, nv);
                push_upd(line, src, nv, tag);
                rsp_q.push_back({2'(src), 64'd0}); rsp_tag.push_back(tag);
            end
            default: begin
                if (cur == expv) begin
                    mwrite(a, wide, nv);
                    push_upd(line, -1, nv, tag);
                    rsp_q.push_back({2'(src), 64'd0});
                end else begin
                    rsp_q.push_back({2'(src), 64'd1});
                end
                rsp_tag.push_back(tag);
            end
        endcase
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cached = cached; cmd_src = 2'(src);
        cmd_addr = 4'(a); cmd_wide = wide; cmd_expect = ex; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (rsp_q.size() != 0 || upd_q.size() != 0 || !cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    check("unexpected response", {rsp_src, rsp_data}, 66'd0);
                    if ({rsp_src, rsp_data} == 66'd0) begin
                        errors++;
                        $display("FAIL unexpected response: actual %h expected none", rsp_data);
                    end
                end else begin
                    check(rsp_tag.pop_front(), {rsp_src, rsp_data}, rsp_q.pop_front());
                end
            end
            if (rst_n && upd_valid && upd_ready) begin
                if (upd_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL unexpected update (R5/R7): actual dst %0d expected none", upd_dst);
                end else begin
                    check(upd_tag.pop_front(), {upd_dst, upd_data}, upd_q.pop_front());
                end
            end
        end
    end

    // acknowledgement responder
    initial begin
        forever begin
            @(negedge clk); #2;
            if (ack_valid) owed--;
            ack_valid = (!ack_hold && owed > 0);
            if (rst_n && upd_valid && upd_ready) owed++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) shr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1 cmd_ready", {65'd0, cmd_ready}, 66'd1);
        check("R1 rsp_valid", {65'd0, rsp_valid}, 66'd0);
        check("R1 upd_valid", {65'd0, upd_valid}, 66'd0);

        do_cmd(2'd0, 1'b0, 0, 3, 1'b0, 0, 0, "R1 R2 read after reset");
        do_cmd(2'd1, 1'b0, 0, 3, 1'b0, 0, 64'h11, "R7 write no sharers");
        do_cmd(2'd0, 1'b1, 1, 3, 1'b0, 0, 0, "R2 R3 cached read src1");
        do_cmd(2'd0, 1'b1, 3, 1, 1'b0, 0, 0, "R3 cached read src3");
        do_cmd(2'd0, 1'b0, 2, 2, 1'b0, 0, 0, "R3 uncached read src2");
        drain();
        do_cmd(2'd1, 1'b0, 1, 2, 1'b0, 0, 64'h22, "R3 R7 write skips writer");
        drain();
        do_cmd(2'd2, 1'b0, 2, 3, 1'b0, 64'h99, 64'h5, "R5 cas mismatch");
        do_cmd(2'd0, 1'b0, 2, 3, 1'b0, 0, 0, "R5 value unchanged");
        drain();
        do_cmd(2'd2, 1'b0, 1, 3, 1'b0, 64'h11, 64'h33, "R4 R6 cas match");
        drain();
        do_cmd(2'd0, 1'b0, 0, 3, 1'b0, 0, 0, "R4 new value stored");
        do_cmd(2'd1, 1'b0, 0, 8, 1'b1, 0, 64'hAAAA_BBBB_CCCC_DDDD, "R7 wide write");
        do_cmd(2'd0, 1'b0, 0, 9, 1'b1, 0, 0, "R2 wide read");
        do_cmd(2'd0, 1'b0, 0, 9, 1'b0, 0, 0, "R2 odd word read");
        do_cmd(2'd2, 1'b0, 2, 8, 1'b1, 64'hAAAA_BBB0_CCCC_DDDD, 64'h1, "R11 wide cas upper differs");
        do_cmd(2'd2, 1'b0, 2, 8, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h7777_0000_0000_0001, "R11 wide cas match");
        do_cmd(2'd0, 1'b0, 2, 8, 1'b1, 0, 0, "R11 wide value stored");
        drain();

        // R8 R9 R10 stalled updates and held acknowledgements
        do_cmd(2'd0, 1'b1, 3, 12, 1'b0, 0, 0, "R3 line3 src3");
        do_cmd(2'd0, 1'b1, 1, 13, 1'b0, 0, 0, "R3 line3 src1");
        do_cmd(2'd0, 1'b1, 2, 14, 1'b0, 0, 0, "R3 line3 src2");
        drain();
        ack_hold = 1'b1;
        upd_ready = 1'b0;
        do_cmd(2'd1, 1'b0, 0, 12, 1'b0, 0, 64'h44, "R8 ordered updates");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #2;
            check("R10 busy while stalled", {65'd0, cmd_ready}, 66'd0);
            check("R8 update held", {63'd0, upd_valid, upd_dst}, {63'd0, 1'b1, 2'd1});
        end
        @(negedge clk);
        upd_ready = 1'b1;
        repeat (6) begin
            @(negedge clk); #2;
            check("R9 no answer before acks", {65'd0, rsp_valid}, 66'd0);
            check("R10 busy while acks owed", {65'd0, cmd_ready}, 66'd0);
        end
        ack_hold = 1'b0;
        drain();
        do_cmd(2'd2, 1'b0, 3, 12, 1'b0, 64'h44, 64'h55, "R6 cas updates all incl requester");
        drain();
        finish_run();
    end
endmodule